// File: doc/BRIEF.md
# Serial-Programmable Sensor Control Register Bank

This block is the control-register slave of an image sensor. A host reaches it over a two-wire I2C-compatible bus. The block samples the bus clock and data lines with its own fast system clock and filters them. It pulls the data line low through an open-drain enable. When its 7-bit device address matches, it takes a register pointer byte followed by data bytes, or it returns register contents starting at the pointer.

The bank holds a clock-divide select, a power-down flag, a sync master/slave selection and two self-clearing command bits. Each command bit sends a single-cycle reset pulse to the sensor. The device address is itself a writable register, so software can move the slave to a new bus address. A bit in that same register picks between two write modes. In the single-register mode, one data byte is written per transaction. In the burst mode, consecutive data bytes go to consecutive registers.

Register map (pointer value: contents): 00h identity, reads 47h. 01h silicon revision, set by a parameter. 05h clock divide in bits 2:1. 06h power-down in bit 0 and the sensor-reset command in bit 1. 07h device address in bits 7:1 and the burst-write enable in bit 0. 09h sync master select in bit 2, a fixed 1 in bit 1 and the timing-reset command in bit 0.

Top module: `sensorRegBank`

## Requirements
- R1: After reset, clkDivSel=0, powerDown=0, syncMaster=0, both pulse outputs are 0 and sdaOe is 0. Registers read back as follows: 00h=47h, 01h=the SILICON_REV parameter, 05h=00h, 06h=00h, 07h=AAh, 09h=02h. The unmapped pointers 02h, 03h, 04h and 08h read 00h.
- R2: The first byte after a START holds a 7-bit address, MSB first, then a R/W bit (0 = write, 1 = read). When the address equals the active device address (55h after reset), the slave ACKs by pulling SDA low during the ninth clock. Otherwise it does not ACK and ignores the bus until the next START.
- R3: Writes to 00h, 01h and unmapped pointers have no effect. Bits that no field occupies read 0. Bit 1 of 09h reads 1 whatever is written.
- R4: With 07h bit 0 = 0, the byte after a write address loads the pointer and the next byte is written there. Any further data bytes are ACKed and change nothing.
- R5: With 07h bit 0 = 1, every data byte is written at the pointer, and the pointer then advances by one.
- R6: A read address returns the register at the pointer and advances the pointer for each byte. A repeated START may precede it. A master ACK asks for the next byte. A master NACK ends the burst and the slave releases SDA (sdaOe=0).
- R7: clkDivSel follows 05h bits 2:1, powerDown follows 06h bit 0 (1 = powered down), and syncMaster follows 09h bit 2 (1 = master). These outputs change only after a write to their register.
- R8: Writing 1 to 06h bit 1 gives a single-cycle sensorResetPulse. Writing 1 to 09h bit 0 gives a single-cycle timingResetPulse. Both bits always read 0.
- R9: 07h bits 7:1 set a new device address. The new address takes effect only at the STOP that ends the writing transaction. A repeated START before that STOP still answers to the old address.
- R10: Pulses on SCL or SDA shorter than FILT_LEN system clocks are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | 1 pulls SDA low (open-drain) |
| clkDivSel | output | 2 | Clock divider select (00 /1, 01 /2, 10 /4, 11 /6) |
| powerDown | output | 1 | 1 = sensor powered down |
| syncMaster | output | 1 | 1 = video sync in master mode |
| sensorResetPulse | output | 1 | One-cycle sensor reset command |
| timingResetPulse | output | 1 | One-cycle reset of timing state machines |

## Verification
One data byte can drive the persistent power-down flag and the self-clearing sensor-reset command in the same cycle. The bench provokes this by writing 03h to 06h in burst mode. The bench passes this case when three things hold: powerDown rises, the pulse counter grows by exactly one high cycle, and a readback of 06h gives 01h. The randomized transactions also hit 06h and 09h with arbitrary data, in both write modes. Every outcome there is compared against a register model in the bench, covering the outputs, the readback and the pulse counts.

// File: rtl/sensorRegsPkg.sv
package sensorRegsPkg;
  localparam logic [7:0] REG_IDENT = 8'h00;
  localparam logic [7:0] REG_REV   = 8'h01;
  localparam logic [7:0] REG_CLKG  = 8'h05;
  localparam logic [7:0] REG_PWR   = 8'h06;
  localparam logic [7:0] REG_SER   = 8'h07;
  localparam logic [7:0] REG_OPS   = 8'h09;
  localparam logic [7:0] SER_INIT  = 8'hAA;

  typedef struct packed {
    logic       loadPtr;
    logic       writeData;
    logic       loadTx;
    logic       stopSeen;
    logic [7:0] rxByte;
  } ctrlStrobes_t;
endpackage

// File: rtl/busLineFilter.sv
module busLineFilter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic filtOut
);
  logic [1:0]          syncQ;
  logic [FILT_LEN-1:0] hist;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= 2'b11;
      hist    <= '1;
      filtOut <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      hist  <= {hist[FILT_LEN-2:0], syncQ[1]};
      if (&hist)       filtOut <= 1'b1;
      else if (~|hist) filtOut <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cSlaveCtrl.sv
module i2cSlaveCtrl
  import sensorRegsPkg::*;
#(
  parameter int FILT_LEN = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclIn,
  input  logic         sdaIn,
  input  logic [6:0]   devAddr,
  input  logic         advWr,
  input  logic [7:0]   rdData,
  output ctrlStrobes_t stb,
  output logic         sdaOe
);
  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_TXACK} state_t;
  typedef enum logic [1:0] {P_ADDR, P_PTR, P_DATA} phase_t;

  logic sclF, sdaF, sclPrev, sdaPrev;
  state_t state;
  phase_t phase;
  logic [7:0] rxShift, txShift;
  logic [2:0] bitCnt;
  logic byteDone, rwBit, firstData, mstAck;

  busLineFilter #(.FILT_LEN(FILT_LEN)) u_sclFilt (.clk(clk), .rstN(rstN), .rawIn(sclIn), .filtOut(sclF));
  busLineFilter #(.FILT_LEN(FILT_LEN)) u_sdaFilt (.clk(clk), .rstN(rstN), .rawIn(sdaIn), .filtOut(sdaF));

  wire sclRise = sclF & ~sclPrev;
  wire sclFall = ~sclF & sclPrev;
  wire startEv = sclF & sclPrev & sdaPrev & ~sdaF;
  wire stopEv  = sclF & sclPrev & ~sdaPrev & sdaF;

  assign sdaOe = (state == S_ACK) | ((state == S_TX) & ~txShift[7]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev   <= 1'b1;
      sdaPrev   <= 1'b1;
      state     <= S_IDLE;
      phase     <= P_ADDR;
      rxShift   <= '0;
      txShift   <= '1;
      bitCnt    <= '0;
      byteDone  <= 1'b0;
      rwBit     <= 1'b0;
      firstData <= 1'b0;
      mstAck    <= 1'b0;
      stb       <= '0;
    end else begin
      stb        <= '0;
      stb.rxByte <= rxShift;
      sclPrev    <= sclF;
      sdaPrev    <= sdaF;
      if (startEv) begin
        state    <= S_RX;
        phase    <= P_ADDR;
        bitCnt   <= '0;
        byteDone <= 1'b0;
      end else if (stopEv) begin
        state        <= S_IDLE;
        stb.stopSeen <= 1'b1;
      end else begin
        case (state)
          S_RX: begin
            if (sclRise) begin
              rxShift <= {rxShift[6:0], sdaF};
              bitCnt  <= bitCnt + 3'd1;
              if (bitCnt == 3'd7) byteDone <= 1'b1;
            end else if (sclFall && byteDone) begin
              byteDone <= 1'b0;
              case (phase)
                P_ADDR: begin
                  if (rxShift[7:1] == devAddr) begin
                    rwBit <= rxShift[0];
                    state <= S_ACK;
                  end else begin
                    state <= S_IDLE;
                  end
                end
                P_PTR: begin
                  stb.loadPtr <= 1'b1;
                  state       <= S_ACK;
                end
                default: begin
                  stb.writeData <= firstData | advWr;
                  firstData     <= 1'b0;
                  state         <= S_ACK;
                end
              endcase
            end
          end
          S_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (phase == P_ADDR && rwBit) begin
                state      <= S_TX;
                txShift    <= rdData;
                stb.loadTx <= 1'b1;
              end else begin
                state <= S_RX;
                if (phase == P_ADDR) begin
                  phase <= P_PTR;
                end else if (phase == P_PTR) begin
                  phase     <= P_DATA;
                  firstData <= 1'b1;
                end
              end
            end
          end
          S_TX: begin
            if (sclFall) begin
              if (bitCnt == 3'd7) begin
                state <= S_TXACK;
              end else begin
                txShift <= {txShift[6:0], 1'b0};
                bitCnt  <= bitCnt + 3'd1;
              end
            end
          end
          S_TXACK: begin
            if (sclRise) begin
              mstAck <= ~sdaF;
            end else if (sclFall) begin
              if (mstAck) begin
                state      <= S_TX;
                bitCnt     <= '0;
                txShift    <= rdData;
                stb.loadTx <= 1'b1;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/regBankDp.sv
module regBankDp
  import sensorRegsPkg::*;
#(
  parameter logic [7:0] IDENT_VALUE = 8'h47,
  parameter logic [7:0] SILICON_REV = 8'h01
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t stb,
  output logic [7:0]   rdData,
  output logic [6:0]   activeAddr,
  output logic         advWr,
  output logic [1:0]   clkDivSel,
  output logic         powerDown,
  output logic         syncMaster,
  output logic         sensorResetPulse,
  output logic         timingResetPulse
);
  logic [7:0] ptr;
  logic [6:0] addrReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr              <= '0;
      addrReg          <= SER_INIT[7:1];
      activeAddr       <= SER_INIT[7:1];
      advWr            <= SER_INIT[0];
      clkDivSel        <= '0;
      powerDown        <= 1'b0;
      syncMaster       <= 1'b0;
      sensorResetPulse <= 1'b0;
      timingResetPulse <= 1'b0;
    end else begin
      sensorResetPulse <= 1'b0;
      timingResetPulse <= 1'b0;
      if (stb.loadPtr) ptr <= stb.rxByte;
      if (stb.loadTx)  ptr <= ptr + 8'd1;
      if (stb.writeData) begin
        case (ptr)
          REG_CLKG: clkDivSel <= stb.rxByte[2:1];
          REG_PWR: begin
            powerDown        <= stb.rxByte[0];
            sensorResetPulse <= stb.rxByte[1];
          end
          REG_SER: begin
            addrReg <= stb.rxByte[7:1];
            advWr   <= stb.rxByte[0];
          end
          REG_OPS: begin
            syncMaster       <= stb.rxByte[2];
            timingResetPulse <= stb.rxByte[0];
          end
          default: ;
        endcase
        if (advWr) ptr <= ptr + 8'd1;
      end
      if (stb.stopSeen) activeAddr <= addrReg;
    end
  end

  always_comb begin
    case (ptr)
      REG_IDENT: rdData = IDENT_VALUE;
      REG_REV:   rdData = SILICON_REV;
      REG_CLKG:  rdData = {5'b0, clkDivSel, 1'b0};
      REG_PWR:   rdData = {7'b0, powerDown};
      REG_SER:   rdData = {addrReg, advWr};
      REG_OPS:   rdData = {5'b0, syncMaster, 2'b10};
      default:   rdData = 8'h00;
    endcase
  end
endmodule

// File: rtl/sensorRegBank.sv
module sensorRegBank
  import sensorRegsPkg::*;
#(
  parameter int         FILT_LEN    = 3,
  parameter logic [7:0] SILICON_REV = 8'h01
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  output logic [1:0] clkDivSel,
  output logic       powerDown,
  output logic       syncMaster,
  output logic       sensorResetPulse,
  output logic       timingResetPulse
);
  ctrlStrobes_t ctrlStb;
  logic [7:0]   rdData;
  logic [6:0]   activeAddr;
  logic         advWr;

  i2cSlaveCtrl #(.FILT_LEN(FILT_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .devAddr(activeAddr), .advWr(advWr), .rdData(rdData),
    .stb(ctrlStb), .sdaOe(sdaOe)
  );

  regBankDp #(.IDENT_VALUE(8'h47), .SILICON_REV(SILICON_REV)) u_dp (
    .clk(clk), .rstN(rstN), .stb(ctrlStb), .rdData(rdData),
    .activeAddr(activeAddr), .advWr(advWr), .clkDivSel(clkDivSel),
    .powerDown(powerDown), .syncMaster(syncMaster),
    .sensorResetPulse(sensorResetPulse), .timingResetPulse(timingResetPulse)
  );
endmodule

// File: rtl/sensorRegBankChk.sv
module sensorRegBankChk (
  input logic       clk,
  input logic       rstN,
  input logic       stopSeen,
  input logic       writeData,
  input logic [6:0] activeAddr,
  input logic [1:0] clkDivSel,
  input logic       powerDown,
  input logic       syncMaster,
  input logic       sensorResetPulse,
  input logic       timingResetPulse
);
  AST_SENSOR_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    sensorResetPulse |=> !sensorResetPulse); // R8
  AST_TIMING_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    timingResetPulse |=> !timingResetPulse); // R8
  AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !writeData |=> !sensorResetPulse && !timingResetPulse); // R8
  AST_ADDR_HOLD_TO_STOP: assert property (@(posedge clk) disable iff (!rstN)
    !stopSeen |=> $stable(activeAddr)); // R9
  AST_POWER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !writeData |=> $stable(powerDown)); // R7
  AST_CONTROLS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !writeData |=> $stable(clkDivSel) && $stable(syncMaster)); // R7
endmodule

bind sensorRegBank sensorRegBankChk u_chk (
  .clk(clk), .rstN(rstN), .stopSeen(ctrlStb.stopSeen), .writeData(ctrlStb.writeData),
  .activeAddr(activeAddr), .clkDivSel(clkDivSel), .powerDown(powerDown),
  .syncMaster(syncMaster), .sensorResetPulse(sensorResetPulse),
  .timingResetPulse(timingResetPulse)
);

// File: tb/sensorRegBank_test.sv
module sensorRegBank_test;
  localparam int Q = 10;
  localparam logic [7:0] EXP_REV = 8'h3C;

  logic clk = 1'b0, rstN = 1'b0, sclM = 1'b1, mLow = 1'b0;
  logic sdaOe, powerDown, syncMaster, sensorResetPulse, timingResetPulse;
  logic [1:0] clkDivSel;
  wire sdaLine = ~(mLow | sdaOe);

  always #4 clk = ~clk;

  sensorRegBank #(.FILT_LEN(3), .SILICON_REV(EXP_REV)) uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .clkDivSel(clkDivSel), .powerDown(powerDown), .syncMaster(syncMaster),
    .sensorResetPulse(sensorResetPulse), .timingResetPulse(timingResetPulse)
  );

  int nChk = 0, nBad = 0, sensCnt = 0, timCnt = 0, expSens = 0, expTim = 0;
  bit glitch = 1'b0, ackAll;
  logic [1:0] mDiv = 2'd0;
  logic mPwd = 1'b0, mAdv = 1'b0, mMaster = 1'b0;
  logic [6:0] mAddrReg = 7'h55, mAddrAct = 7'h55;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [12];

  always @(posedge clk) begin
    if (sensorResetPulse) sensCnt++;
    if (timingResetPulse) timCnt++;
  end

  function automatic logic [7:0] expRead(input logic [7:0] p);
    case (p)
      8'h00: return 8'h47;
      8'h01: return EXP_REV;
      8'h05: return {5'b0, mDiv, 1'b0};
      8'h06: return {7'b0, mPwd};
      8'h07: return {mAddrReg, mAdv};
      8'h09: return {5'b0, mMaster, 2'b10};
      default: return 8'h00;
    endcase
  endfunction

  task automatic modelApply(input logic [7:0] p, input logic [7:0] d);
    case (p)
      8'h05: mDiv = d[2:1];
      8'h06: begin mPwd = d[0]; if (d[1]) expSens++; end
      8'h07: begin mAddrReg = d[7:1]; mAdv = d[0]; end
      8'h09: begin mMaster = d[2]; if (d[0]) expTim++; end
      default: ;
    endcase
  endtask

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2cStart();
    mLow = 1'b0; waitc(Q); sclM = 1'b1; waitc(Q);
    mLow = 1'b1; waitc(Q); sclM = 1'b0; waitc(Q);
  endtask

  task automatic i2cStop();
    mLow = 1'b1; waitc(Q); sclM = 1'b1; waitc(Q); mLow = 1'b0; waitc(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      mLow = ~b[i]; waitc(Q); sclM = 1'b1; waitc(Q);
      if (glitch && i == 4) begin sclM = 1'b0; waitc(1); sclM = 1'b1; end
      waitc(Q); sclM = 1'b0; waitc(Q);
    end
    mLow = 1'b0; waitc(Q); sclM = 1'b1; waitc(Q);
    acked = (sdaLine == 1'b0);
    waitc(Q); sclM = 1'b0; waitc(Q);
  endtask

  task automatic recvByte(input bit mAck, output logic [7:0] b);
    mLow = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      waitc(Q); sclM = 1'b1; waitc(Q); b[i] = sdaLine; waitc(Q); sclM = 1'b0;
    end
    waitc(Q); mLow = mAck; waitc(Q); sclM = 1'b1; waitc(2 * Q); sclM = 1'b0; waitc(Q);
    mLow = 1'b0;
  endtask

  task automatic writeTxn(input logic [7:0] p, input int n);
    bit a;
    logic [7:0] wp;
    logic oldAdv;
    ackAll = 1'b1;
    i2cStart();
    sendByte({mAddrAct, 1'b0}, a); ackAll &= a;
    sendByte(p, a); ackAll &= a;
    for (int k = 0; k < n; k++) begin sendByte(wbuf[k], a); ackAll &= a; end
    i2cStop();
    wp = p;
    for (int k = 0; k < n; k++) begin
      if (k == 0 || mAdv) begin
        oldAdv = mAdv;
        modelApply(wp, wbuf[k]);
        if (oldAdv) wp = wp + 8'd1;
      end
    end
    mAddrAct = mAddrReg;
  endtask

  task automatic readTxn(input logic [7:0] p, input int n);
    bit a;
    ackAll = 1'b1;
    i2cStart();
    sendByte({mAddrAct, 1'b0}, a); ackAll &= a;
    sendByte(p, a); ackAll &= a;
    i2cStart();
    sendByte({mAddrAct, 1'b1}, a); ackAll &= a;
    for (int k = 0; k < n; k++) recvByte(k < n - 1, rbuf[k]);
    checkEq("R6 SDA released after master NACK", sdaOe, 1'b0);
    i2cStop();
  endtask

  task automatic checkOutputs(input string tag);
    checkEq({tag, " clkDivSel"}, clkDivSel, mDiv);
    checkEq({tag, " powerDown"}, powerDown, mPwd);
    checkEq({tag, " syncMaster"}, syncMaster, mMaster);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    logic [7:0] pick [6];
    bit a, modeB;
    logic [7:0] p;
    int n;
    string tag;
    pick = '{8'h00, 8'h01, 8'h05, 8'h06, 8'h09, 8'h02};
    void'($urandom(32'h5EC0_1234));
    waitc(5); rstN = 1'b1; waitc(5);

    // R1 reset outputs and register contents
    checkOutputs("R1 reset");
    checkEq("R1 reset sdaOe", sdaOe, 1'b0);
    checkEq("R1 reset pulses", {sensorResetPulse, timingResetPulse}, 2'b00);
    readTxn(8'h00, 10);
    checkEq("R2 ACK default address", ackAll, 1'b1);
    for (int k = 0; k < 10; k++) checkEq("R1 reset readback", rbuf[k], expRead(8'(k)));

    // R3 read-only and reserved bits
    wbuf[0] = 8'hFF; writeTxn(8'h00, 1); writeTxn(8'h01, 1); writeTxn(8'h02, 1);
    wbuf[0] = 8'h00; writeTxn(8'h09, 1);
    readTxn(8'h00, 3);
    checkEq("R3 identity unchanged", rbuf[0], 8'h47);
    checkEq("R3 revision unchanged", rbuf[1], EXP_REV);
    checkEq("R3 unmapped reads 0", rbuf[2], 8'h00);
    readTxn(8'h09, 1);
    checkEq("R3 reserved bit of 09h reads 1", rbuf[0], 8'h02);

    // R4 standard mode: extra bytes ignored
    wbuf[0] = 8'h06; wbuf[1] = 8'hFF; wbuf[2] = 8'hFF;
    writeTxn(8'h05, 3);
    checkEq("R4 extra bytes ACKed", ackAll, 1'b1);
    checkEq("R4 first byte written", clkDivSel, 2'd3);
    checkEq("R4 power-down untouched", powerDown, 1'b0);
    checkEq("R4 no reset pulse", sensCnt, 0);
    readTxn(8'h06, 1);
    checkEq("R4 06h readback", rbuf[0], 8'h00);

    // R5 burst mode
    wbuf[0] = 8'hAB; writeTxn(8'h07, 1);
    wbuf[0] = 8'h04; wbuf[1] = 8'h01; writeTxn(8'h05, 2);
    checkOutputs("R5 burst");
    readTxn(8'h05, 3);
    for (int k = 0; k < 3; k++) checkEq("R5 burst readback", rbuf[k], expRead(8'h05 + 8'(k)));

    // R8 same-cycle persistent flag and self-clearing command
    wbuf[0] = 8'h03; writeTxn(8'h06, 1);
    waitc(4);
    checkEq("R8 sensor pulse count", sensCnt, expSens);
    checkEq("R7 power-down set with pulse", powerDown, 1'b1);
    readTxn(8'h06, 1);
    checkEq("R8 06h command bit reads 0", rbuf[0], 8'h01);
    wbuf[0] = 8'h05; writeTxn(8'h09, 1);
    waitc(4);
    checkEq("R8 timing pulse count", timCnt, expTim);
    checkEq("R7 sync master", syncMaster, 1'b1);
    readTxn(8'h09, 1);
    checkEq("R8 09h command bit reads 0", rbuf[0], 8'h06);

    // R9 readdressing takes effect at STOP
    i2cStart();
    sendByte({mAddrAct, 1'b0}, a); sendByte(8'h07, a); sendByte({7'h3C, 1'b1}, a);
    modelApply(8'h07, {7'h3C, 1'b1});
    i2cStart();
    sendByte({7'h55, 1'b0}, a);
    checkEq("R9 old address after repeated START", a, 1'b1);
    i2cStop();
    mAddrAct = mAddrReg;
    i2cStart(); sendByte({7'h55, 1'b0}, a); i2cStop();
    checkEq("R2 R9 old address NACKed after STOP", a, 1'b0);
    i2cStart(); sendByte({7'h3C, 1'b0}, a); i2cStop();
    checkEq("R9 new address ACKed", a, 1'b1);
    wbuf[0] = 8'hAA; writeTxn(8'h07, 1);
    checkEq("R9 restore ACK", ackAll, 1'b1);
    i2cStart(); sendByte({7'h12, 1'b0}, a); i2cStop();
    checkEq("R2 foreign address NACKed", a, 1'b0);

    // R10 SCL glitches filtered
    glitch = 1'b1;
    wbuf[0] = 8'h04; writeTxn(8'h05, 1);
    glitch = 1'b0;
    checkEq("R10 ACK with glitches", ackAll, 1'b1);
    checkEq("R10 write with glitches", clkDivSel, 2'd2);

    // random mix of modes, pointers and data
    for (int it = 0; it < 16; it++) begin
      modeB = 1'($urandom % 2);
      wbuf[0] = {mAddrAct, modeB}; writeTxn(8'h07, 1);
      p = pick[$urandom % 6];
      n = 1 + int'($urandom % 3);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      writeTxn(p, n);
      tag = modeB ? "R5 random burst" : "R4 random single";
      checkEq({tag, " ACK"}, ackAll, 1'b1);
      readTxn(p, n);
      for (int k = 0; k < n; k++) checkEq({tag, " readback"}, rbuf[k], expRead(p + 8'(k)));
      checkOutputs("R7 random");
    end
    waitc(4);
    checkEq("R8 random sensor pulses", sensCnt, expSens);
    checkEq("R8 random timing pulses", timCnt, expTim);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule